// File: doc/BRIEF.md
# Interrupt Controller Command Word Decoder

This block is the register front end of one programmable interrupt controller. It sits between a byte-wide two-address register port and the controller's priority core. It runs the initialization word sequence, turns operation commands into one-cycle control pulses for the core, and picks the byte that a read returns. It also holds a separate edge/level trigger register whose writable bits are fixed by a parameter.

A write to address 0 with bit 4 set starts initialization. It clears the mask, the vector base and every mode flag, and it sends a clear pulse to the core. That pulse also clears the core's request, in-service and rotation state and drops any pending interrupt output. The next writes to address 1 are consumed as the second, third and, if requested, fourth initialization words. After that, address 1 loads the interrupt mask. Writes to address 0 with bit 4 clear are operation commands: bit 3 selects between the read/poll/special-mask command and the end-of-interrupt/rotation command family. The priority logic itself lives in the core, which feeds its request, in-service and poll answer back for reads.

Top module: `pic_cmd_decoder`

## Requirements
- R1: A write to address 0 with bit 4 set clears `imr`, `vec_base`, `auto_eoi`, `sfn_mode`, `spec_mask`, `read_isr_sel`, `poll_pending` and `rot_on_aeoi`, and pulses `init_clr` for one cycle. The write takes effect in the cycle after the write strobe. Bit 0 of that byte records whether a fourth initialization word will follow.
- R2: The first address-1 write after initialization starts sets `vec_base` to the data with bits 2..0 forced to zero. It does not change `imr`.
- R3: The second address-1 write after initialization starts (the third word) changes no output. It ends the sequence when bit 0 of the starting byte was 0, so the next address-1 write loads `imr`.
- R4: When a fourth word was requested, the third address-1 write is that word. Its bit 4 sets `sfn_mode` and its bit 1 sets `auto_eoi`, and it returns the sequence to normal mode.
- R5: In normal mode an address-1 write loads `imr` with the full byte.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 sets `poll_pending` when bit 2 is 1. When bit 1 is 1 it copies bit 0 into `read_isr_sel`. When bit 6 is 1 it copies bit 5 into `spec_mask`. A field whose enable bit is 0 is left unchanged.
- R7: An address-0 write with bits 4 and 3 both 0 decodes bits 7..5 as a command code:
  - 0 clears `rot_on_aeoi` and 4 sets it.
  - 1 pulses `eoi_nonspec`, 5 pulses `eoi_rotate` and 3 pulses `eoi_specific`.
  - 6 pulses `prio_set` and 7 pulses `rot_specific`.
  - 2 pulses nothing.
  
  Each pulse lasts one cycle, in the cycle after the write. At most one pulse is high at a time. `cmd_level` then holds bits 2..0 of the command byte.
- R8: While `poll_pending` is 1, a read returns `{5'b0, poll_irq_in}` when `poll_valid_in` is 1 and 8'h07 otherwise. Such a read drives `poll_ack` when a request is valid, and it clears `poll_pending` at the next clock edge.
- R9: Without a pending poll, a read at address 0 returns `isr_in` when `read_isr_sel` is 1 and `irr_in` when it is 0. A read at address 1 returns `imr`.
- R10: An `elcr_wr` strobe loads `elcr` with the write data ANDed with the `ELCR_MASK` parameter. Bits outside the mask always read as 0, so those lines stay edge-triggered.
- R11: After reset every register output is zero and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register port address bit |
| wr_en | input | 1 | Write strobe for the command port |
| rd_en | input | 1 | Read strobe for the command port |
| wr_data | input | 8 | Write data byte |
| elcr_wr | input | 1 | Write strobe for the trigger mode register |
| irr_in | input | 8 | Request register from the core |
| isr_in | input | 8 | In-service register from the core |
| poll_valid_in | input | 1 | Core has a request that poll would return |
| poll_irq_in | input | 3 | Line number poll would return |
| rd_data | output | 8 | Read data byte |
| poll_ack | output | 1 | Poll read consumed a request |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, bits 2..0 zero |
| elcr | output | 8 | Edge/level trigger register |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| sfn_mode | output | 1 | Special fully nested mode |
| spec_mask | output | 1 | Special mask mode |
| read_isr_sel | output | 1 | Address-0 reads return in-service when 1 |
| poll_pending | output | 1 | Next read is a poll |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| init_clr | output | 1 | Pulse: clear core state, drop output |
| eoi_nonspec | output | 1 | Pulse: non-specific end-of-interrupt |
| eoi_rotate | output | 1 | Pulse: rotating non-specific end-of-interrupt |
| eoi_specific | output | 1 | Pulse: specific end-of-interrupt |
| prio_set | output | 1 | Pulse: set lowest priority line |
| rot_specific | output | 1 | Pulse: rotate on specific end-of-interrupt |
| cmd_level | output | 3 | Line number of the last command |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One uses the mask value for a master controller (8'hF8) and the other uses the value for a cascaded slave (8'hDE). A single all-ones write to the trigger register therefore shows both sets of forced-edge lines at once. Every other behaviour is independent of that parameter, and the two copies must agree on it. The fourth-word and no-fourth-word initialization paths, every command code and the poll read with and without a request are each driven by their own task.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int DW      = 8;
    localparam int LVL_W   = 3;
    localparam int VEC_LOW = 3;

    typedef enum logic [1:0] {
        SEQ_RUN = 2'd0,
        SEQ_W2  = 2'd1,
        SEQ_W3  = 2'd2,
        SEQ_W4  = 2'd3
    } seq_st_e;

    typedef enum logic [2:0] {
        OP_ROT_AEOI_CLR = 3'd0,
        OP_EOI_NS       = 3'd1,
        OP_NOP          = 3'd2,
        OP_EOI_SPEC     = 3'd3,
        OP_ROT_AEOI_SET = 3'd4,
        OP_EOI_ROT      = 3'd5,
        OP_SET_PRIO     = 3'd6,
        OP_ROT_SPEC     = 3'd7
    } op_code_e;

    typedef struct packed {
        seq_st_e          st;
        logic             want_w4;
        logic [DW-1:0]    imr;
        logic [DW-1:0]    vbase;
        logic             aeoi;
        logic             sfn;
        logic             clr;
    } seq_state_t;

    typedef struct packed {
        logic             smm;
        logic             rsel;
        logic             poll;
        logic             rot_aeoi;
        logic             eoi_ns;
        logic             eoi_rot;
        logic             eoi_spec;
        logic             prio;
        logic             rot_spec;
        logic [LVL_W-1:0] lvl;
    } cmd_state_t;

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic          wr_port1,
    input  logic [DW-1:0] wdat,
    output logic [DW-1:0] imr_o,
    output logic [DW-1:0] vbase_o,
    output logic          aeoi_o,
    output logic          sfn_o,
    output logic          clr_o
);

    localparam int AEOI_BIT = 1;
    localparam int SFN_BIT  = 4;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.clr = 1'b0;
        if (wr_start) begin
            s_d.st      = SEQ_W2;
            s_d.want_w4 = wdat[0];
            s_d.imr     = '0;
            s_d.vbase   = '0;
            s_d.aeoi    = 1'b0;
            s_d.sfn     = 1'b0;
            s_d.clr     = 1'b1;
        end else if (wr_port1) begin
            unique case (s_q.st)
                SEQ_RUN: s_d.imr = wdat;
                SEQ_W2: begin
                    s_d.vbase = {wdat[DW-1:VEC_LOW], {VEC_LOW{1'b0}}};
                    s_d.st    = SEQ_W3;
                end
                SEQ_W3: s_d.st = s_q.want_w4 ? SEQ_W4 : SEQ_RUN;
                SEQ_W4: begin
                    s_d.sfn  = wdat[SFN_BIT];
                    s_d.aeoi = wdat[AEOI_BIT];
                    s_d.st   = SEQ_RUN;
                end
                default: s_d.st = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign imr_o   = s_q.imr;
    assign vbase_o = s_q.vbase;
    assign aeoi_o  = s_q.aeoi;
    assign sfn_o   = s_q.sfn;
    assign clr_o   = s_q.clr;

endmodule

// File: rtl/pic_op_decode.sv
module pic_op_decode
    import pic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             wr_sel,
    input  logic             wr_eoi,
    input  logic             poll_done,
    input  logic [DW-1:0]    wdat,
    output logic             smm_o,
    output logic             rsel_o,
    output logic             poll_o,
    output logic             rot_aeoi_o,
    output logic             eoi_ns_o,
    output logic             eoi_rot_o,
    output logic             eoi_spec_o,
    output logic             prio_o,
    output logic             rot_spec_o,
    output logic [LVL_W-1:0] lvl_o
);

    cmd_state_t c_d, c_q;
    op_code_e   code;

    assign code = op_code_e'(wdat[DW-1:DW-3]);

    always_comb begin
        c_d          = c_q;
        c_d.eoi_ns   = 1'b0;
        c_d.eoi_rot  = 1'b0;
        c_d.eoi_spec = 1'b0;
        c_d.prio     = 1'b0;
        c_d.rot_spec = 1'b0;
        if (poll_done) c_d.poll = 1'b0;
        if (wr_start) begin
            c_d.smm      = 1'b0;
            c_d.rsel     = 1'b0;
            c_d.poll     = 1'b0;
            c_d.rot_aeoi = 1'b0;
        end else if (wr_sel) begin
            if (wdat[2]) c_d.poll = 1'b1;
            if (wdat[1]) c_d.rsel = wdat[0];
            if (wdat[6]) c_d.smm  = wdat[5];
        end else if (wr_eoi) begin
            c_d.lvl = wdat[LVL_W-1:0];
            unique case (code)
                OP_ROT_AEOI_CLR: c_d.rot_aeoi = 1'b0;
                OP_ROT_AEOI_SET: c_d.rot_aeoi = 1'b1;
                OP_EOI_NS:       c_d.eoi_ns   = 1'b1;
                OP_EOI_ROT:      c_d.eoi_rot  = 1'b1;
                OP_EOI_SPEC:     c_d.eoi_spec = 1'b1;
                OP_SET_PRIO:     c_d.prio     = 1'b1;
                OP_ROT_SPEC:     c_d.rot_spec = 1'b1;
                default:         ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign smm_o      = c_q.smm;
    assign rsel_o     = c_q.rsel;
    assign poll_o     = c_q.poll;
    assign rot_aeoi_o = c_q.rot_aeoi;
    assign eoi_ns_o   = c_q.eoi_ns;
    assign eoi_rot_o  = c_q.eoi_rot;
    assign eoi_spec_o = c_q.eoi_spec;
    assign prio_o     = c_q.prio;
    assign rot_spec_o = c_q.rot_spec;
    assign lvl_o      = c_q.lvl;

endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
    import pic_cmd_pkg::*;
(
    input  logic             addr,
    input  logic             poll,
    input  logic             poll_valid,
    input  logic [LVL_W-1:0] poll_irq,
    input  logic             rsel,
    input  logic [DW-1:0]    irr,
    input  logic [DW-1:0]    isr,
    input  logic [DW-1:0]    imr,
    output logic [DW-1:0]    rdat
);

    localparam logic [DW-1:0] NO_REQ = DW'((1 << LVL_W) - 1);

    always_comb begin
        if (poll)      rdat = poll_valid ? DW'(poll_irq) : NO_REQ;
        else if (addr) rdat = imr;
        else if (rsel) rdat = isr;
        else           rdat = irr;
    end

endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg
    import pic_cmd_pkg::*;
#(
    parameter logic [DW-1:0] MASK = 8'hF8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdat,
    output logic [DW-1:0] trig_o
);

    logic [DW-1:0] t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (wr) t_d = wdat & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign trig_o = t_q;

endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import pic_cmd_pkg::*;
#(
    parameter logic [7:0] ELCR_MASK = 8'hF8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    input  logic       elcr_wr,
    input  logic [7:0] irr_in,
    input  logic [7:0] isr_in,
    input  logic       poll_valid_in,
    input  logic [2:0] poll_irq_in,
    output logic [7:0] rd_data,
    output logic       poll_ack,
    output logic [7:0] imr,
    output logic [7:0] vec_base,
    output logic [7:0] elcr,
    output logic       auto_eoi,
    output logic       sfn_mode,
    output logic       spec_mask,
    output logic       read_isr_sel,
    output logic       poll_pending,
    output logic       rot_on_aeoi,
    output logic       init_clr,
    output logic       eoi_nonspec,
    output logic       eoi_rotate,
    output logic       eoi_specific,
    output logic       prio_set,
    output logic       rot_specific,
    output logic [2:0] cmd_level
);

    logic wr_start, wr_sel, wr_eoi, wr_port1, poll_done;

    assign wr_start  = wr_en && !addr && wr_data[4];
    assign wr_sel    = wr_en && !addr && !wr_data[4] && wr_data[3];
    assign wr_eoi    = wr_en && !addr && !wr_data[4] && !wr_data[3];
    assign wr_port1  = wr_en && addr;
    assign poll_done = rd_en && poll_pending;
    assign poll_ack  = poll_done && poll_valid_in;

    pic_init_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_start(wr_start),
        .wr_port1(wr_port1),
        .wdat    (wr_data),
        .imr_o   (imr),
        .vbase_o (vec_base),
        .aeoi_o  (auto_eoi),
        .sfn_o   (sfn_mode),
        .clr_o   (init_clr)
    );

    pic_op_decode u_op (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_start  (wr_start),
        .wr_sel    (wr_sel),
        .wr_eoi    (wr_eoi),
        .poll_done (poll_done),
        .wdat      (wr_data),
        .smm_o     (spec_mask),
        .rsel_o    (read_isr_sel),
        .poll_o    (poll_pending),
        .rot_aeoi_o(rot_on_aeoi),
        .eoi_ns_o  (eoi_nonspec),
        .eoi_rot_o (eoi_rotate),
        .eoi_spec_o(eoi_specific),
        .prio_o    (prio_set),
        .rot_spec_o(rot_specific),
        .lvl_o     (cmd_level)
    );

    pic_read_mux u_rd (
        .addr      (addr),
        .poll      (poll_pending),
        .poll_valid(poll_valid_in),
        .poll_irq  (poll_irq_in),
        .rsel      (read_isr_sel),
        .irr       (irr_in),
        .isr       (isr_in),
        .imr       (imr),
        .rdat      (rd_data)
    );

    pic_trig_reg #(.MASK(ELCR_MASK)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (elcr_wr),
        .wdat  (wr_data),
        .trig_o(elcr)
    );

endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk #(
    parameter logic [7:0] ELCR_MASK = 8'hF8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wr_data,
    input logic [7:0] imr,
    input logic [7:0] vec_base,
    input logic [7:0] elcr,
    input logic       auto_eoi,
    input logic       sfn_mode,
    input logic       spec_mask,
    input logic       read_isr_sel,
    input logic       poll_pending,
    input logic       rot_on_aeoi,
    input logic       init_clr,
    input logic       eoi_nonspec,
    input logic       eoi_rotate,
    input logic       eoi_specific,
    input logic       prio_set,
    input logic       rot_specific
);

    p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wr_data[4]) |=> (init_clr && imr == 8'h00 &&
            vec_base == 8'h00 && !auto_eoi && !sfn_mode && !spec_mask &&
            !read_isr_sel && !poll_pending && !rot_on_aeoi));

    p_vec_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_base[2:0] == 3'b000);

    p_imr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(imr));

    p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoi_nonspec, eoi_rotate, eoi_specific, prio_set, rot_specific}));

    p_ns_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wr_data[7:3] == 5'b00100) |=> eoi_nonspec);

    p_poll_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_pending && !wr_en) |=> !poll_pending);

    p_trig_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (elcr & ~ELCR_MASK) == 8'h00);

endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.ELCR_MASK(ELCR_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wr_data     (wr_data),
    .imr         (imr),
    .vec_base    (vec_base),
    .elcr        (elcr),
    .auto_eoi    (auto_eoi),
    .sfn_mode    (sfn_mode),
    .spec_mask   (spec_mask),
    .read_isr_sel(read_isr_sel),
    .poll_pending(poll_pending),
    .rot_on_aeoi (rot_on_aeoi),
    .init_clr    (init_clr),
    .eoi_nonspec (eoi_nonspec),
    .eoi_rotate  (eoi_rotate),
    .eoi_specific(eoi_specific),
    .prio_set    (prio_set),
    .rot_specific(rot_specific)
);

// File: tb/pic_cmd_decoder_test.sv
`timescale 1ns/1ps
module pic_cmd_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, elcr_wr = 1'b0;
    logic [7:0] wr_data = 8'h00, irr_in = 8'h00, isr_in = 8'h00;
    logic       poll_valid_in = 1'b0;
    logic [2:0] poll_irq_in = 3'd0;

    logic [7:0] rd_data, imr, vec_base, elcr, elcr_s, rd_s;
    logic       poll_ack, auto_eoi, sfn_mode, spec_mask, read_isr_sel;
    logic       poll_pending, rot_on_aeoi, init_clr;
    logic       eoi_nonspec, eoi_rotate, eoi_specific, prio_set, rot_specific;
    logic [2:0] cmd_level;

    logic [7:0] s_imr, s_vb;
    logic [2:0] s_lvl;
    logic       s_pa, s_ae, s_sf, s_sm, s_rs, s_pp, s_ra, s_ic, s_en, s_er, s_es, s_ps, s_rp;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pic_cmd_decoder #(.ELCR_MASK(8'hF8)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .elcr_wr(elcr_wr), .irr_in(irr_in), .isr_in(isr_in),
        .poll_valid_in(poll_valid_in), .poll_irq_in(poll_irq_in),
        .rd_data(rd_data), .poll_ack(poll_ack), .imr(imr), .vec_base(vec_base),
        .elcr(elcr), .auto_eoi(auto_eoi), .sfn_mode(sfn_mode),
        .spec_mask(spec_mask), .read_isr_sel(read_isr_sel),
        .poll_pending(poll_pending), .rot_on_aeoi(rot_on_aeoi),
        .init_clr(init_clr), .eoi_nonspec(eoi_nonspec), .eoi_rotate(eoi_rotate),
        .eoi_specific(eoi_specific), .prio_set(prio_set),
        .rot_specific(rot_specific), .cmd_level(cmd_level)
    );

    pic_cmd_decoder #(.ELCR_MASK(8'hDE)) uut_slave (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .elcr_wr(elcr_wr), .irr_in(irr_in), .isr_in(isr_in),
        .poll_valid_in(poll_valid_in), .poll_irq_in(poll_irq_in),
        .rd_data(rd_s), .poll_ack(s_pa), .imr(s_imr), .vec_base(s_vb),
        .elcr(elcr_s), .auto_eoi(s_ae), .sfn_mode(s_sf),
        .spec_mask(s_sm), .read_isr_sel(s_rs),
        .poll_pending(s_pp), .rot_on_aeoi(s_ra),
        .init_clr(s_ic), .eoi_nonspec(s_en), .eoi_rotate(s_er),
        .eoi_specific(s_es), .prio_set(s_ps),
        .rot_specific(s_rp), .cmd_level(s_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] pulses();
        return {eoi_nonspec, eoi_rotate, eoi_specific, prio_set, rot_specific};
    endfunction

    // drive at a falling edge, return one cycle later with the write applied
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d, output logic ack);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        d = rd_data; ack = poll_ack;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 imr", imr, 8'h00);
        chk("R11 vec_base", vec_base, 8'h00);
        chk("R11 elcr", elcr, 8'h00);
        chk("R11 flags", {auto_eoi, sfn_mode, spec_mask, read_isr_sel, poll_pending, rot_on_aeoi}, 0);
        chk("R11 pulses", {init_clr, pulses()}, 0);
    endtask

    task automatic t_init_w4();
        wr(1'b0, 8'h11);
        chk("R1 init_clr pulse", init_clr, 1);
        wr(1'b1, 8'h4D);
        chk("R2 vec_base low bits cleared", vec_base, 8'h48);
        chk("R2 imr untouched", imr, 8'h00);
        chk("R1 init_clr one cycle", init_clr, 0);
        wr(1'b1, 8'h04);
        chk("R3 third word no effect imr", imr, 8'h00);
        chk("R3 third word no effect vec", vec_base, 8'h48);
        chk("R3 third word no effect modes", {sfn_mode, auto_eoi}, 0);
        wr(1'b1, 8'h12);
        chk("R4 fourth word modes", {sfn_mode, auto_eoi}, 2'b11);
        chk("R4 fourth word not mask", imr, 8'h00);
        wr(1'b1, 8'hA5);
        chk("R5 mask load after sequence", imr, 8'hA5);
    endtask

    task automatic t_init_no_w4();
        wr(1'b0, 8'h10);
        chk("R1 second init clears imr", imr, 8'h00);
        chk("R1 second init clears modes", {sfn_mode, auto_eoi}, 0);
        wr(1'b1, 8'h27);
        chk("R2 vec_base", vec_base, 8'h20);
        wr(1'b1, 8'hFF);
        chk("R3 third word leaves imr", imr, 8'h00);
        wr(1'b1, 8'h3C);
        chk("R3 sequence ended, imr loaded", imr, 8'h3C);
        chk("R3 modes stay clear", {sfn_mode, auto_eoi}, 0);
        wr(1'b1, 8'hC3);
        chk("R5 mask reload", imr, 8'hC3);
    endtask

    task automatic t_sel_cmd();
        logic [7:0] d; logic a;
        irr_in = 8'h5A; isr_in = 8'h81;
        rd(1'b0, d, a);
        chk("R9 irr read", d, 8'h5A);
        rd(1'b1, d, a);
        chk("R9 imr read", d, 8'hC3);
        wr(1'b0, 8'h0B);
        chk("R6 read select set", read_isr_sel, 1);
        rd(1'b0, d, a);
        chk("R9 isr read", d, 8'h81);
        wr(1'b0, 8'h08);
        chk("R6 select gated by bit1", read_isr_sel, 1);
        wr(1'b0, 8'h0A);
        chk("R6 read select clear", read_isr_sel, 0);
        wr(1'b0, 8'h68);
        chk("R6 special mask set", spec_mask, 1);
        wr(1'b0, 8'h28);
        chk("R6 special mask gated by bit6", spec_mask, 1);
        wr(1'b0, 8'h48);
        chk("R6 special mask clear", spec_mask, 0);
        chk("R6 no poll without bit2", poll_pending, 0);
    endtask

    task automatic t_eoi_cmds();
        wr(1'b0, 8'h80);
        chk("R7 rotate-on-aeoi set", rot_on_aeoi, 1);
        chk("R7 code4 no pulse", pulses(), 0);
        wr(1'b0, 8'h00);
        chk("R7 rotate-on-aeoi clear", rot_on_aeoi, 0);
        wr(1'b0, 8'h20);
        chk("R7 nonspecific eoi", pulses(), 5'b10000);
        @(negedge clk);
        chk("R7 pulse one cycle", pulses(), 0);
        wr(1'b0, 8'hA0);
        chk("R7 rotating eoi", pulses(), 5'b01000);
        wr(1'b0, 8'h63);
        chk("R7 specific eoi", pulses(), 5'b00100);
        chk("R7 specific level", cmd_level, 3);
        wr(1'b0, 8'hC6);
        chk("R7 set priority", pulses(), 5'b00010);
        chk("R7 priority level", cmd_level, 6);
        wr(1'b0, 8'hE1);
        chk("R7 rotate specific", pulses(), 5'b00001);
        chk("R7 rotate level", cmd_level, 1);
        wr(1'b0, 8'h45);
        chk("R7 code2 nothing", {pulses(), rot_on_aeoi}, 0);
    endtask

    task automatic t_poll();
        logic [7:0] d; logic a;
        wr(1'b0, 8'h0C);
        chk("R6 poll set", poll_pending, 1);
        poll_valid_in = 1'b1; poll_irq_in = 3'd5;
        rd(1'b1, d, a);
        chk("R8 poll data", d, 8'h05);
        chk("R8 poll ack", a, 1);
        chk("R8 poll cleared", poll_pending, 0);
        rd(1'b1, d, a);
        chk("R9 imr after poll", d, 8'hC3);
        wr(1'b0, 8'h0C);
        poll_valid_in = 1'b0;
        rd(1'b0, d, a);
        chk("R8 poll none", d, 8'h07);
        chk("R8 no ack", a, 0);
        poll_irq_in = 3'd0;
    endtask

    task automatic t_trig();
        @(negedge clk);
        wr_data = 8'hFF; elcr_wr = 1'b1;
        @(negedge clk);
        elcr_wr = 1'b0;
        chk("R10 master mask", elcr, 8'hF8);
        chk("R10 slave mask", elcr_s, 8'hDE);
        chk("R10 imr untouched", imr, 8'hC3);
    endtask

    task automatic t_init_clear_all();
        wr(1'b0, 8'h6B);
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h0C);
        wr(1'b0, 8'h10);
        chk("R1 init clears flags",
            {auto_eoi, sfn_mode, spec_mask, read_isr_sel, poll_pending, rot_on_aeoi}, 0);
        chk("R1 init clears regs", {imr, vec_base}, 0);
        chk("R1 init pulse", init_clr, 1);
        chk("R10 trig kept", elcr, 8'hF8);
        chk("R1 slave agrees", {s_imr, s_ic}, 9'h001);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_w4();
        t_init_no_w4();
        t_sel_cmd();
        t_eoi_cmds();
        t_poll();
        t_trig();
        t_init_clear_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule